// File: doc/BRIEF.md
# Multi-Page-Size Translation Buffer

A fully associative address-translation buffer that holds a parameterized number of entries (32 by default). Each entry maps one region whose size is chosen per entry: a 1 MB section, a 64 KB large page or a 4 KB small page. Every entry compares the lookup address under a mask taken from its own size, so all three granularities share one associative array. A lookup presents a 32-bit virtual address, and the hit flag, the physical address and the permission bits come back from registers on the next clock.

Misses are resolved outside the block by a hardware table walker. The walker writes each new entry through a fill port. The slot that receives the fill is chosen by a round-robin pointer. A flush input drops every mapping at once. Instruction and data translation each use their own instance. The block does no permission checking and has no domain logic.

Top module: `xlat_buf`

## Requirements
- R1: A lookup requested with `lk_en` in one cycle produces its result on the next clock edge. `rs_valid` is high in exactly the cycle after each request. When no request was made, `rs_hit`, `rs_pa` and `rs_perm` are all zero.
- R2: `fl_size` encodings are 2'b00 for 4 KB, 2'b01 for 64 KB, 2'b10 for 1 MB, and 2'b11 is treated as 4 KB. A valid entry matches when the virtual address bits [31:12] agree with its stored tag for 4 KB, bits [31:16] for 64 KB, or bits [31:20] for 1 MB.
- R3: On a hit, `rs_pa` takes the entry's frame bits above the page-offset boundary (bit 12, 16 or 20, set by the size). Below that boundary it carries the lookup address bits unchanged, and `rs_perm` equals the stored permission bits.
- R4: A fill writes the slot named by a pointer that is 0 after reset and advances by one after each accepted fill, wrapping from ENTRIES-1 to 0. A new fill therefore overwrites the oldest slot.
- R5: `flush` invalidates every entry in one cycle. A fill asserted in the same cycle as a flush is ignored and does not move the pointer.
- R6: When more than one valid entry matches, the result comes from the entry with the lowest index.
- R7: A lookup that matches no valid entry returns `rs_hit`=0, `rs_pa`=0 and `rs_perm`=0.
- R8: After reset all entries are invalid and every result output is zero.
- R9: A lookup made in the same cycle as a fill or flush sees the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_en | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| fl_en | input | 1 | Fill request from the walker |
| fl_va | input | 32 | Virtual address of the new mapping |
| fl_pa | input | 32 | Physical frame of the new mapping |
| fl_size | input | 2 | Page size code of the new mapping |
| fl_perm | input | PERM_W | Permission bits of the new mapping |
| flush | input | 1 | Invalidate all entries |
| rs_valid | output | 1 | Result of the previous cycle's lookup is present |
| rs_hit | output | 1 | Lookup hit |
| rs_pa | output | 32 | Translated physical address |
| rs_perm | output | PERM_W | Permission bits of the hit entry |

## Verification
A lookup's result is due one edge after its request. A fill or flush affects only lookups made in later cycles, so one made in the same cycle still sees the old contents. The bench drives each cycle's inputs on the falling edge and computes the expected result from its model before it applies that cycle's write. It checks all four result outputs at the next falling edge. This keeps the one-cycle result latency and the read-before-write ordering apart in every check, across both random traffic and the directed overlap, wrap and flush cases.

// File: rtl/xlat_buf.sv
module xlat_buf #(
  parameter int ENTRIES = 32,
  parameter int PERM_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_en,
  input  logic [31:0]       lk_va,
  input  logic              fl_en,
  input  logic [31:0]       fl_va,
  input  logic [31:0]       fl_pa,
  input  logic [1:0]        fl_size,
  input  logic [PERM_W-1:0] fl_perm,
  input  logic              flush,
  output logic              rs_valid,
  output logic              rs_hit,
  output logic [31:0]       rs_pa,
  output logic [PERM_W-1:0] rs_perm
);
  localparam int PW = $clog2(ENTRIES);

  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] match;
  logic [19:0]        tag [ENTRIES];
  logic [19:0]        frm [ENTRIES];
  logic [1:0]         sz  [ENTRIES];
  logic [PERM_W-1:0]  prm [ENTRIES];
  logic [PW-1:0]      ptr;

  logic              sel_hit;
  logic [31:0]       sel_pa;
  logic [PERM_W-1:0] sel_perm;

  function automatic logic [19:0] pmask(input logic [1:0] s);
    case (s)
      2'b01:   return 20'hFFFF0;
      2'b10:   return 20'hFFF00;
      default: return 20'hFFFFF;
    endcase
  endfunction

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = vld[i] && (((tag[i] ^ lk_va[31:12]) & pmask(sz[i])) == 20'h0);
  end

  always_comb begin
    sel_hit  = 1'b0;
    sel_pa   = '0;
    sel_perm = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel_hit  = 1'b1;
        sel_pa   = {(frm[i] & pmask(sz[i])) | (lk_va[31:12] & ~pmask(sz[i])), lk_va[11:0]};
        sel_perm = prm[i];
      end
    end
  end

  wire do_fill = fl_en && !flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld      <= '0;
      ptr      <= '0;
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_pa    <= '0;
      rs_perm  <= '0;
    end else begin
      rs_valid <= lk_en;
      rs_hit   <= lk_en && sel_hit;
      rs_pa    <= (lk_en && sel_hit) ? sel_pa : '0;
      rs_perm  <= (lk_en && sel_hit) ? sel_perm : '0;
      if (flush) begin
        vld <= '0;
      end else if (do_fill) begin
        vld[ptr] <= 1'b1;
        ptr      <= ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && do_fill) begin
      tag[ptr] <= fl_va[31:12];
      frm[ptr] <= fl_pa[31:12];
      sz[ptr]  <= fl_size;
      prm[ptr] <= fl_perm;
    end
  end
endmodule

// File: rtl/xlat_buf_chk.sv
module xlat_buf_chk #(
  parameter int ENTRIES = 32,
  parameter int PERM_W  = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       lk_en,
  input logic [31:0]                lk_va,
  input logic                       fl_en,
  input logic                       flush,
  input logic                       rs_valid,
  input logic                       rs_hit,
  input logic [31:0]                rs_pa,
  input logic [PERM_W-1:0]          rs_perm,
  input logic [ENTRIES-1:0]         vld,
  input logic [$clog2(ENTRIES)-1:0] ptr
);
  p_valid_follows_req_r1: assert property (@(posedge clk) disable iff (rst)
    lk_en |=> rs_valid);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !lk_en |=> (!rs_valid && !rs_hit && rs_pa == 32'h0));
  p_offset_kept_r3: assert property (@(posedge clk) disable iff (rst)
    lk_en |=> (!rs_hit || rs_pa[11:0] == $past(lk_va[11:0])));
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (fl_en && !flush) |=> (ptr == $past(ptr) + 1'b1) && vld[$past(ptr)]);
  p_flush_all_r5: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld == '0) && $stable(ptr));
  p_miss_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rs_valid && !rs_hit) |-> (rs_pa == 32'h0 && rs_perm == '0));
endmodule

bind xlat_buf xlat_buf_chk #(.ENTRIES(ENTRIES), .PERM_W(PERM_W)) u_chk (
  .clk(clk), .rst(rst), .lk_en(lk_en), .lk_va(lk_va), .fl_en(fl_en),
  .flush(flush), .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_pa(rs_pa),
  .rs_perm(rs_perm), .vld(vld), .ptr(ptr)
);

// File: tb/xlat_buf_bench.sv
module xlat_buf_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, lk_en, fl_en, flush;
  logic [31:0] lk_va, fl_va, fl_pa;
  logic [1:0]  fl_size;
  logic [3:0]  fl_perm;
  logic        rs_valid, rs_hit;
  logic [31:0] rs_pa;
  logic [3:0]  rs_perm;

  xlat_buf u_xlat_buf (
    .clk(clk), .rst(rst), .lk_en(lk_en), .lk_va(lk_va), .fl_en(fl_en),
    .fl_va(fl_va), .fl_pa(fl_pa), .fl_size(fl_size), .fl_perm(fl_perm),
    .flush(flush), .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_pa(rs_pa),
    .rs_perm(rs_perm)
  );

  int checks = 0;
  int errors = 0;

  bit         mv [32];
  logic [19:0] mt [32];
  logic [19:0] mf [32];
  logic [1:0]  ms [32];
  logic [3:0]  mp [32];
  int          mptr = 0;
  logic [31:0] recent [8];

  function automatic logic [19:0] fmask(input logic [1:0] s);
    if (s == 2'b01) return 20'hFFFF0;
    if (s == 2'b10) return 20'hFFF00;
    return 20'hFFFFF;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic le, input logic [31:0] va, input logic fe,
                      input logic [31:0] fva, input logic [31:0] fpa,
                      input logic [1:0] fs, input logic [3:0] fp,
                      input logic fl, input string req);
    logic eh;
    logic [31:0] epa;
    logic [3:0] epr;
    lk_en = le; lk_va = va; fl_en = fe; fl_va = fva; fl_pa = fpa;
    fl_size = fs; fl_perm = fp; flush = fl;
    eh = 1'b0; epa = 32'h0; epr = 4'h0;
    if (le) begin
      for (int i = 0; i < 32; i++) begin
        if (!eh && mv[i] && (((mt[i] ^ va[31:12]) & fmask(ms[i])) == 20'h0)) begin
          eh  = 1'b1;
          epa = {(mf[i] & fmask(ms[i])) | (va[31:12] & ~fmask(ms[i])), va[11:0]};
          epr = mp[i];
        end
      end
    end
    if (fl) begin
      for (int i = 0; i < 32; i++) mv[i] = 1'b0;
    end else if (fe) begin
      mv[mptr] = 1'b1; mt[mptr] = fva[31:12]; mf[mptr] = fpa[31:12];
      ms[mptr] = fs; mp[mptr] = fp;
      mptr = (mptr + 1) % 32;
    end
    @(negedge clk);
    chk({req, " valid"}, 64'(rs_valid), 64'(le));
    chk({req, " hit"},   64'(rs_hit),   64'(eh));
    chk({req, " pa"},    64'(rs_pa),    64'(epa));
    chk({req, " perm"},  64'(rs_perm),  64'(epr));
  endtask

  task automatic fill(input logic [31:0] fva, input logic [31:0] fpa,
                      input logic [1:0] fs, input logic [3:0] fp, input string req);
    step(1'b0, 32'h0, 1'b1, fva, fpa, fs, fp, 1'b0, req);
  endtask

  task automatic look(input logic [31:0] va, input string req);
    step(1'b1, va, 1'b0, 32'h0, 32'h0, 2'b00, 4'h0, 1'b0, req);
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; lk_en = 0; lk_va = 0; fl_en = 0; fl_va = 0; fl_pa = 0;
    fl_size = 0; fl_perm = 0; flush = 0;
    for (int i = 0; i < 8; i++) recent[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk("R8 valid", 64'(rs_valid), 64'd0);
    chk("R8 hit", 64'(rs_hit), 64'd0);
    chk("R8 pa", 64'(rs_pa), 64'd0);
    rst = 1'b0;

    look(32'h1234_5678, "R7 empty");
    fill(32'h1230_0000, 32'hABC0_0000, 2'b10, 4'h5, "R4 fill0");
    fill(32'h1234_5000, 32'h5555_5000, 2'b00, 4'h3, "R4 fill1");
    look(32'h1234_5678, "R6 overlap");
    look(32'h123F_FFFC, "R3 section");
    fill(32'h0007_0000, 32'h7FFF_0000, 2'b01, 4'h9, "R2 large fill");
    look(32'h0007_ABCD, "R2 large hit");
    look(32'h0008_0000, "R7 large miss");
    fill(32'h00A0_0000, 32'h0BB0_0000, 2'b11, 4'hC, "R2 code3 fill");
    look(32'h00A0_0ABC, "R2 code3 small hit");
    look(32'h00A0_1ABC, "R2 code3 small miss");
    step(1'b1, 32'h4000_0123, 1'b1, 32'h4000_0000, 32'h6000_0000, 2'b00, 4'h1, 1'b0, "R9 same cycle");
    look(32'h4000_0123, "R9 next cycle");
    step(1'b1, 32'h4000_0123, 1'b1, 32'h5000_0000, 32'h6100_0000, 2'b00, 4'h2, 1'b1, "R5 flush with fill");
    look(32'h4000_0123, "R5 after flush");
    look(32'h5000_0000, "R5 fill dropped");
    for (int i = 0; i < 40; i++)
      fill(32'(i) << 12, 32'h8000_0000 | (32'(i) << 12), 2'b00, 4'(i), "R4 wrap fill");
    look(32'h0000_0010, "R4 slot reused");
    look(32'h0002_7010, "R4 last fill");
    look(32'h0000_8010, "R4 middle fill");

    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [31:0] a;
      r = $urandom_range(0, 99);
      a = $urandom & 32'h00F3_FFFF;
      if (r < 3) begin
        step(1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 2'b00, 4'h0, 1'b1, "R5 random flush");
      end else if (r < 30) begin
        recent[n % 8] = a;
        fill(a, $urandom, 2'($urandom_range(0, 3)), 4'($urandom), "R2 random fill");
      end else if (r < 80) begin
        a = recent[$urandom_range(0, 7)] ^ ($urandom & 32'h000F_FFFF);
        step(1'b1, a, r < 45, $urandom & 32'h00F3_FFFF, $urandom,
             2'($urandom_range(0, 3)), 4'($urandom), 1'b0, "R3 random lookup");
      end else if (r < 90) begin
        look(a, "R7 random lookup");
      end else begin
        step(1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 2'b00, 4'h0, 1'b0, "R1 idle");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule